// File: doc/BRIEF.md
# DMA Channel Configuration Register Bank

This block stores the programming registers of a four-channel DMA engine and serves them on a simple word-addressed register bus. The bus has an address, a write strobe with write data, and a read strobe with read data. Each channel owns five registers: control, transfer count, destination address, source address, and the address of the next scatter/gather descriptor. A status word shared by all channels shows which channels are enabled.

The transfer logic reads every register continuously through wide per-channel output buses. It can overwrite the count, destination and source of any channel with dedicated update strobes, for example while it advances through a transfer. The bus side is protected while a channel runs. A write to a busy channel is dropped. The only exception is a control write that turns the channel off.

Top module: `dma_cfg_bank`

## Requirements
- R1: Channel n (0..3) uses the word addresses 0x100 + 8·n + k. The register offset k is 0 for control, 1 for count, 2 for destination, 3 for source and 4 for descriptor address. A write to a disabled channel's register is read back unchanged and leaves the other channels untouched.
- R2: Address 0x120 reads as a status word. Bit n holds channel n's enable bit and all higher bits are zero. Writes to 0x120 have no effect.
- R3: Read data appears on `busRdata` one clock after the cycle in which `busRd` is high. It holds its value while `busRd` is low. When a read and a write hit the same register in one cycle, the read returns the value from before the write.
- R4: A read of any address outside R1 and R2 returns zero. This includes offsets 5 to 7 inside a channel's window. A write to such an address changes no register.
- R5: While bit 31 of a channel's control register is 1, bus writes to its count, destination, source and descriptor registers have no effect.
- R6: While a channel is enabled, a control write whose bit 31 is 1 has no effect on any bit of that control register.
- R7: While a channel is enabled, a control write whose bit 31 is 0 stores the full written word and so disables the channel.
- R8: A disabled channel accepts writes to all five of its registers. A control write with bit 31 set enables the channel.
- R9: A hardware update strobe for count, destination or source loads its value on the next clock, whether or not the channel is enabled. In the same cycle it takes priority over any bus write to that register.
- R10: The `chCtrl`, `chCount`, `chDst`, `chSrc` and `chDesc` outputs always show the current register contents. Channel n occupies bits [32n+31:32n].
- R11: After reset every register, the status word and `busRdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 10 | Word address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| hwCountWe | input | 4 | Per-channel count update strobe |
| hwCountVal | input | 128 | Per-channel count update value |
| hwDstWe | input | 4 | Per-channel destination update strobe |
| hwDstVal | input | 128 | Per-channel destination update value |
| hwSrcWe | input | 4 | Per-channel source update strobe |
| hwSrcVal | input | 128 | Per-channel source update value |
| chCtrl | output | 128 | Control registers, all channels |
| chCount | output | 128 | Count registers, all channels |
| chDst | output | 128 | Destination registers, all channels |
| chSrc | output | 128 | Source registers, all channels |
| chDesc | output | 128 | Descriptor address registers, all channels |

## Verification
Every register drives a port directly, so a wrong stored value shows on the channel output buses at the clock edge that stores it. A wrong enable bit shows in the same way and changes which later writes are dropped. A decode fault that sends a write to the wrong channel or offset shows one cycle later as a change on another channel's output. A read-mux or status fault stays hidden until a read of that address, and then shows on `busRdata` one clock later. The reference model is compared against every output on every cycle, so each of these faults is caught at the first cycle it becomes visible.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

  typedef enum logic [2:0] {
    FLD_CTRL  = 3'd0,
    FLD_COUNT = 3'd1,
    FLD_DST   = 3'd2,
    FLD_SRC   = 3'd3,
    FLD_DESC  = 3'd4
  } cfg_fld_e;

  // Strobes from the decode/protect control to the register datapath.
  typedef struct packed {
    logic     wrEn;      // write accepted (decoded and not protected)
    logic     rdEn;      // read strobe seen this cycle
    logic     rdHit;     // read hits a channel register
    logic     rdStatus;  // read hits the status word
    logic [7:0] chIdx;   // target channel
    cfg_fld_e fld;       // target register within the channel
  } cfg_strobe_t;

endpackage

// File: rtl/dma_cfg_ctrl.sv
module dma_cfg_ctrl
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 10,
  parameter int BASE_ADDR   = 'h100,
  parameter int CH_STRIDE   = 8,
  parameter int NUM_FLD     = 5,
  parameter int STATUS_ADDR = 'h120
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              wdataEnBit,
  input  logic              busRd,
  input  logic [NUM_CH-1:0] chEnable,
  output cfg_strobe_t       stb
);

  localparam int OFF_W = $clog2(CH_STRIDE);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int SPAN  = NUM_CH * CH_STRIDE;

  logic [ADDR_W-1:0] rel;
  logic [OFF_W-1:0]  off;
  logic [CH_W-1:0]   chSel;
  logic              inWindow;
  logic              regHit;
  logic              isStatus;
  logic              chanOn;
  logic              writeOk;

  always_comb begin
    rel      = busAddr - ADDR_W'(BASE_ADDR);
    off      = rel[OFF_W-1:0];
    chSel    = rel[OFF_W +: CH_W];
    inWindow = ({1'b0, busAddr} >= (ADDR_W+1)'(BASE_ADDR)) &&
               ({1'b0, busAddr} <  (ADDR_W+1)'(BASE_ADDR + SPAN));
    regHit   = inWindow && (int'(off) < NUM_FLD);
    isStatus = (busAddr == ADDR_W'(STATUS_ADDR));
    chanOn   = chEnable[chSel];
    // A running channel only takes a control write that clears its enable.
    writeOk  = !chanOn || ((off == '0) && !wdataEnBit);

    stb.wrEn     = busWr && regHit && writeOk;
    stb.rdEn     = busRd;
    stb.rdHit    = busRd && regHit;
    stb.rdStatus = busRd && isStatus;
    stb.chIdx    = 8'(rel >> OFF_W);
    stb.fld      = cfg_fld_e'(3'(off));
  end

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 31
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfg_strobe_t              stb,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic [NUM_CH-1:0]        hwCountWe,
  input  logic [NUM_CH*DATA_W-1:0] hwCountVal,
  input  logic [NUM_CH-1:0]        hwDstWe,
  input  logic [NUM_CH*DATA_W-1:0] hwDstVal,
  input  logic [NUM_CH-1:0]        hwSrcWe,
  input  logic [NUM_CH*DATA_W-1:0] hwSrcVal,
  output logic [NUM_CH-1:0]        chEnable,
  output logic [NUM_CH*DATA_W-1:0] chCtrl,
  output logic [NUM_CH*DATA_W-1:0] chCount,
  output logic [NUM_CH*DATA_W-1:0] chDst,
  output logic [NUM_CH*DATA_W-1:0] chSrc,
  output logic [NUM_CH*DATA_W-1:0] chDesc,
  output logic [DATA_W-1:0]        busRdata
);

  localparam int CH_W = $clog2(NUM_CH);

  logic [DATA_W-1:0] regCtrl  [NUM_CH];
  logic [DATA_W-1:0] regCount [NUM_CH];
  logic [DATA_W-1:0] regDst   [NUM_CH];
  logic [DATA_W-1:0] regSrc   [NUM_CH];
  logic [DATA_W-1:0] regDesc  [NUM_CH];
  logic [DATA_W-1:0] rdNext;

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic selW;
    assign selW = stb.wrEn && (stb.chIdx == 8'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regCtrl[i]  <= '0;
        regCount[i] <= '0;
        regDst[i]   <= '0;
        regSrc[i]   <= '0;
        regDesc[i]  <= '0;
      end else begin
        if (selW && stb.fld == FLD_CTRL) regCtrl[i] <= busWdata;
        if (selW && stb.fld == FLD_DESC) regDesc[i] <= busWdata;
        // Engine updates win over the bus for the same register.
        if (hwCountWe[i])                      regCount[i] <= hwCountVal[i*DATA_W +: DATA_W];
        else if (selW && stb.fld == FLD_COUNT) regCount[i] <= busWdata;
        if (hwDstWe[i])                        regDst[i] <= hwDstVal[i*DATA_W +: DATA_W];
        else if (selW && stb.fld == FLD_DST)   regDst[i] <= busWdata;
        if (hwSrcWe[i])                        regSrc[i] <= hwSrcVal[i*DATA_W +: DATA_W];
        else if (selW && stb.fld == FLD_SRC)   regSrc[i] <= busWdata;
      end
    end

    assign chEnable[i]                  = regCtrl[i][EN_BIT];
    assign chCtrl[i*DATA_W +: DATA_W]   = regCtrl[i];
    assign chCount[i*DATA_W +: DATA_W]  = regCount[i];
    assign chDst[i*DATA_W +: DATA_W]    = regDst[i];
    assign chSrc[i*DATA_W +: DATA_W]    = regSrc[i];
    assign chDesc[i*DATA_W +: DATA_W]   = regDesc[i];

    // R5: a running channel keeps its count unless the engine loads it
    a_r5_count_locked: assert property (@(posedge clk) disable iff (!rstN)
      (regCtrl[i][EN_BIT] && !hwCountWe[i]) |=> $stable(regCount[i]));
    // R5: descriptor address of a running channel never moves
    a_r5_desc_locked: assert property (@(posedge clk) disable iff (!rstN)
      regCtrl[i][EN_BIT] |=> $stable(regDesc[i]));
    // R9: engine count update lands on the next clock
    a_r9_hw_count: assert property (@(posedge clk) disable iff (!rstN)
      hwCountWe[i] |=> (regCount[i] == $past(hwCountVal[i*DATA_W +: DATA_W])));
    // R7: the enable bit changes only through an accepted control write
    a_r7_enable_via_bus: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regCtrl[i][EN_BIT]) |->
        $past(stb.wrEn && stb.fld == FLD_CTRL && stb.chIdx == 8'(i)));
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdHit) begin
      case (stb.fld)
        FLD_CTRL:  rdNext = regCtrl[stb.chIdx[CH_W-1:0]];
        FLD_COUNT: rdNext = regCount[stb.chIdx[CH_W-1:0]];
        FLD_DST:   rdNext = regDst[stb.chIdx[CH_W-1:0]];
        FLD_SRC:   rdNext = regSrc[stb.chIdx[CH_W-1:0]];
        FLD_DESC:  rdNext = regDesc[stb.chIdx[CH_W-1:0]];
        default:   rdNext = '0;
      endcase
    end else if (stb.rdStatus) begin
      rdNext = DATA_W'(chEnable);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busRdata <= '0;
    else if (stb.rdEn)  busRdata <= rdNext;
  end

  // R3: read data holds between reads
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(busRdata));
  // R4: reads that miss every register return zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && !stb.rdHit && !stb.rdStatus) |=> (busRdata == '0));

endmodule

// File: rtl/dma_cfg_bank.sv
module dma_cfg_bank
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 10,
  parameter int BASE_ADDR   = 'h100,
  parameter int CH_STRIDE   = 8,
  parameter int STATUS_ADDR = 'h120,
  parameter int EN_BIT      = 31
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWr,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic                     busRd,
  output logic [DATA_W-1:0]        busRdata,
  input  logic [NUM_CH-1:0]        hwCountWe,
  input  logic [NUM_CH*DATA_W-1:0] hwCountVal,
  input  logic [NUM_CH-1:0]        hwDstWe,
  input  logic [NUM_CH*DATA_W-1:0] hwDstVal,
  input  logic [NUM_CH-1:0]        hwSrcWe,
  input  logic [NUM_CH*DATA_W-1:0] hwSrcVal,
  output logic [NUM_CH*DATA_W-1:0] chCtrl,
  output logic [NUM_CH*DATA_W-1:0] chCount,
  output logic [NUM_CH*DATA_W-1:0] chDst,
  output logic [NUM_CH*DATA_W-1:0] chSrc,
  output logic [NUM_CH*DATA_W-1:0] chDesc
);

  localparam int NUM_FLD = 5;

  cfg_strobe_t       stb;
  logic [NUM_CH-1:0] chEnable;

  dma_cfg_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .CH_STRIDE(CH_STRIDE), .NUM_FLD(NUM_FLD), .STATUS_ADDR(STATUS_ADDR)
  ) uCtrl (
    .busAddr(busAddr), .busWr(busWr), .wdataEnBit(busWdata[EN_BIT]),
    .busRd(busRd), .chEnable(chEnable), .stb(stb)
  );

  dma_cfg_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .EN_BIT(EN_BIT)
  ) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .hwCountWe(hwCountWe), .hwCountVal(hwCountVal),
    .hwDstWe(hwDstWe), .hwDstVal(hwDstVal),
    .hwSrcWe(hwSrcWe), .hwSrcVal(hwSrcVal),
    .chEnable(chEnable), .chCtrl(chCtrl), .chCount(chCount),
    .chDst(chDst), .chSrc(chSrc), .chDesc(chDesc), .busRdata(busRdata)
  );

endmodule

// File: tb/tb_dma_cfg_bank.sv
module tb_dma_cfg_bank;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [9:0]   busAddr = '0;
  logic         busWr = 1'b0;
  logic [31:0]  busWdata = '0;
  logic         busRd = 1'b0;
  logic [31:0]  busRdata;
  logic [3:0]   hwCountWe = '0, hwDstWe = '0, hwSrcWe = '0;
  logic [127:0] hwCountVal = '0, hwDstVal = '0, hwSrcVal = '0;
  logic [127:0] chCtrl, chCount, chDst, chSrc, chDesc;

  dma_cfg_bank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRd(busRd), .busRdata(busRdata),
    .hwCountWe(hwCountWe), .hwCountVal(hwCountVal),
    .hwDstWe(hwDstWe), .hwDstVal(hwDstVal),
    .hwSrcWe(hwSrcWe), .hwSrcVal(hwSrcVal),
    .chCtrl(chCtrl), .chCount(chCount), .chDst(chDst),
    .chSrc(chSrc), .chDesc(chDesc)
  );

  always #5 clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  string curReq = "R11";

  // Behavioural reference model
  logic [31:0] mCtrl[4], mCnt[4], mDst[4], mSrc[4], mDesc[4];
  logic [31:0] mRdata;

  function automatic logic [31:0] modelRead(int a);
    int ch, off;
    logic [31:0] st;
    if (a >= 'h100 && a < 'h120 && (a % 8) < 5) begin
      ch  = (a - 'h100) / 8;
      off = a % 8;
      case (off)
        0: return mCtrl[ch];
        1: return mCnt[ch];
        2: return mDst[ch];
        3: return mSrc[ch];
        default: return mDesc[ch];
      endcase
    end
    if (a == 'h120) begin
      st = '0;
      for (int c = 0; c < 4; c++) st[c] = mCtrl[c][31];
      return st;
    end
    return '0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mCtrl[c] = '0; mCnt[c] = '0; mDst[c] = '0; mSrc[c] = '0; mDesc[c] = '0;
      end
      mRdata = '0;
    end else begin
      int a, ch, off;
      a = int'(busAddr);
      if (busRd) mRdata = modelRead(a);
      if (busWr && a >= 'h100 && a < 'h120 && (a % 8) < 5) begin
        ch  = (a - 'h100) / 8;
        off = a % 8;
        if (!mCtrl[ch][31] || (off == 0 && !busWdata[31])) begin
          case (off)
            0: mCtrl[ch] = busWdata;
            1: mCnt[ch]  = busWdata;
            2: mDst[ch]  = busWdata;
            3: mSrc[ch]  = busWdata;
            default: mDesc[ch] = busWdata;
          endcase
        end
      end
      for (int c = 0; c < 4; c++) begin
        if (hwCountWe[c]) mCnt[c] = hwCountVal[c*32 +: 32];
        if (hwDstWe[c])   mDst[c] = hwDstVal[c*32 +: 32];
        if (hwSrcWe[c])   mSrc[c] = hwSrcVal[c*32 +: 32];
      end
    end
  end

  // Per-cycle comparison of every output against the model (R10 and current phase)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit bad;
      bad = 1'b0;
      nChecks++;
      for (int c = 0; c < 4; c++) begin
        if (chCtrl[c*32 +: 32] !== mCtrl[c]) begin
          bad = 1'b1;
          $display("FAIL %s/R10 ch%0d ctrl actual=%h expected=%h", curReq, c, chCtrl[c*32 +: 32], mCtrl[c]);
        end
        if (chCount[c*32 +: 32] !== mCnt[c]) begin
          bad = 1'b1;
          $display("FAIL %s/R10 ch%0d count actual=%h expected=%h", curReq, c, chCount[c*32 +: 32], mCnt[c]);
        end
        if (chDst[c*32 +: 32] !== mDst[c]) begin
          bad = 1'b1;
          $display("FAIL %s/R10 ch%0d dst actual=%h expected=%h", curReq, c, chDst[c*32 +: 32], mDst[c]);
        end
        if (chSrc[c*32 +: 32] !== mSrc[c]) begin
          bad = 1'b1;
          $display("FAIL %s/R10 ch%0d src actual=%h expected=%h", curReq, c, chSrc[c*32 +: 32], mSrc[c]);
        end
        if (chDesc[c*32 +: 32] !== mDesc[c]) begin
          bad = 1'b1;
          $display("FAIL %s/R10 ch%0d desc actual=%h expected=%h", curReq, c, chDesc[c*32 +: 32], mDesc[c]);
        end
      end
      if (busRdata !== mRdata) begin
        bad = 1'b1;
        $display("FAIL %s/R3 rdata actual=%h expected=%h", curReq, busRdata, mRdata);
      end
      if (bad) nFails++;
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = 10'(a); busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busAddr = 10'(a); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    chk(busRdata, exp, req, $sformatf("read 0x%0h", a));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    @(negedge clk);
    chk(chCtrl[31:0], 32'h0, "R11", "ch0 ctrl after reset");
    chk(busRdata, 32'h0, "R11", "rdata after reset");
    rdChk('h120, 32'h0, "R11");
    rdChk('h11C, 32'h0, "R11");

    // R1: address map and readback on disabled channels
    curReq = "R1";
    wr('h100, 32'h0000_0C01); wr('h101, 32'h10); wr('h102, 32'h2000);
    wr('h103, 32'h3000);      wr('h104, 32'h4000);
    wr('h118, 32'h0000_0003); wr('h119, 32'h20); wr('h11A, 32'hA000);
    wr('h11B, 32'hB000);      wr('h11C, 32'hC000);
    rdChk('h100, 32'h0000_0C01, "R1"); rdChk('h101, 32'h10, "R1");
    rdChk('h102, 32'h2000, "R1");      rdChk('h103, 32'h3000, "R1");
    rdChk('h104, 32'h4000, "R1");
    rdChk('h118, 32'h3, "R1");         rdChk('h119, 32'h20, "R1");
    rdChk('h11A, 32'hA000, "R1");      rdChk('h11B, 32'hB000, "R1");
    rdChk('h11C, 32'hC000, "R1");
    rdChk('h109, 32'h0, "R1");

    // R4: unmapped addresses
    curReq = "R4";
    wr('h105, 32'hDEAD_BEEF); wr('h10F, 32'h1234_5678);
    rdChk('h105, 32'h0, "R4"); rdChk('h10F, 32'h0, "R4");
    rdChk('h000, 32'h0, "R4"); rdChk('h3FF, 32'h0, "R4");
    rdChk('h125, 32'h0, "R4"); rdChk('h101, 32'h10, "R4");

    // R2: status word
    curReq = "R2";
    wr('h110, 32'h8000_0000);
    rdChk('h120, 32'h4, "R2");
    wr('h120, 32'hFFFF_FFFF);
    rdChk('h120, 32'h4, "R2");

    // R5: writes to a running channel's data registers are dropped
    curReq = "R5";
    wr('h108, 32'h8000_00AB);
    wr('h109, 32'h55); wr('h10A, 32'h66); wr('h10B, 32'h77); wr('h10C, 32'h88);
    rdChk('h109, 32'h0, "R5"); rdChk('h10A, 32'h0, "R5");
    rdChk('h10B, 32'h0, "R5"); rdChk('h10C, 32'h0, "R5");

    // R6: control write keeping enable set is dropped
    curReq = "R6";
    wr('h108, 32'h8000_0001);
    rdChk('h108, 32'h8000_00AB, "R6");

    // R7: control write clearing enable is taken in full
    curReq = "R7";
    wr('h108, 32'h0000_0011);
    rdChk('h108, 32'h0000_0011, "R7");
    rdChk('h120, 32'h4, "R7");

    // R8: disabled channel accepts writes, enable via control
    curReq = "R8";
    wr('h109, 32'h66);
    rdChk('h109, 32'h66, "R8");
    wr('h108, 32'h8000_0000);
    rdChk('h120, 32'h6, "R8");

    // R9: engine updates on a running channel
    curReq = "R9";
    @(negedge clk);
    hwCountWe[1] = 1'b1; hwCountVal[63:32] = 32'h999;
    hwSrcWe[1]   = 1'b1; hwSrcVal[63:32]   = 32'h5000;
    @(negedge clk);
    hwCountWe = '0; hwSrcWe = '0;
    chk(chCount[63:32], 32'h999, "R9", "hw count on enabled ch1");
    chk(chSrc[63:32], 32'h5000, "R9", "hw src on enabled ch1");
    // R9: engine update beats a bus write to the same register
    busAddr = 10'h119; busWdata = 32'hAAAA; busWr = 1'b1;
    hwCountWe[3] = 1'b1; hwCountVal[127:96] = 32'h1234;
    @(negedge clk);
    busWr = 1'b0; hwCountWe = '0;
    chk(chCount[127:96], 32'h1234, "R9", "hw beats bus on ch3 count");

    // R3: read-before-write in one cycle, then hold
    curReq = "R3";
    busAddr = 10'h119; busWdata = 32'h77; busWr = 1'b1; busRd = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    chk(busRdata, 32'h1234, "R3", "read returns pre-write value");
    chk(chCount[127:96], 32'h77, "R3", "same-cycle write stored");
    @(negedge clk);
    chk(busRdata, 32'h1234, "R3", "rdata held without read");

    // R10: outputs track registers
    curReq = "R10";
    chk(chCtrl[63:32], 32'h8000_0000, "R10", "ch1 ctrl output");
    chk(chDesc[31:0], 32'h4000, "R10", "ch0 desc output");

    // Mixed traffic compared against the model every cycle
    curReq = "R10";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) busAddr = 10'($urandom);
      else busAddr = 10'('h100 + $urandom_range(0, 35));
      busWdata  = $urandom;
      busWr     = ($urandom_range(0, 1) == 1);
      busRd     = ($urandom_range(0, 1) == 1);
      hwCountWe = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      hwDstWe   = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      hwSrcWe   = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      for (int c = 0; c < 4; c++) begin
        hwCountVal[c*32 +: 32] = $urandom;
        hwDstVal[c*32 +: 32]   = $urandom;
        hwSrcVal[c*32 +: 32]   = $urandom;
      end
    end
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; hwCountWe = '0; hwDstWe = '0; hwSrcWe = '0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule